// File: doc/BRIEF.md
# Multiplier Busy Stall Interlock

This block sits beside the decode stage of a simple in-order integer core that shares one multi-cycle multiplier between several instruction classes. Each cycle it looks at the class code of the instruction waiting in decode, a valid flag and the global pipeline advance. From these it decides whether that instruction must be held in decode. It also reports whether the multiplier is still working.

A double-length multiply leaves decode and then passes through execute and two memory-access stages. The second of these drives the multiplier. After that the multiplier keeps running for a fixed four-cycle tail, and this tail does not depend on the pipeline. The slot directly after a double-length multiply is always held in decode for one cycle. Instructions that do not touch the multiplier carry on after that slot. An instruction that does touch the multiplier stays held until its own multiplier access, two stages after decode, would land exactly when the tail runs out.

A small state machine follows the multiply through its pre-access stages:
- `PH_IDLE` goes to `PH_EX` when a double-length multiply issues.
- `PH_EX` goes to `PH_MA1` on advance.
- `PH_MA1` goes to `PH_MA2` on advance.
- `PH_MA2` goes back to `PH_IDLE` on advance. That transition also loads the tail counter.

Each state holds while advance is low.

Top module: `mbi_interlock`

## Requirements
- R1: Class codes on `dec_class`: 0 means no multiplier use; 1 is a signed and 2 an unsigned double-length multiply; 3 is a long multiply-accumulate; 4 is a word multiply-accumulate; 5 is a word multiply; 6 moves a result register to a general register and 7 stores one to memory; 8 loads a result register from a general register and 9 loads one from memory. Codes 10 to 15 are treated like code 0.
- R2: An instruction issues (leaves decode) in a cycle where `dec_valid` and `pipe_adv` are high and `dec_stall` is low. With the multiplier idle and nothing pending, a double-length multiply is not stalled.
- R3: In the cycle after a double-length multiply issues, a valid decode slot is stalled whatever its class. With `pipe_adv` high, an instruction of class 0 or 10 to 15 placed right behind it is stalled for exactly one cycle.
- R4: With `pipe_adv` held high, `mul_busy` is high in exactly cycles 4 to 7 after the issue cycle of a double-length multiply, where the issue cycle is cycle 0.
- R5: An instruction of class 3 to 9 placed right behind a double-length multiply, with `pipe_adv` high, is stalled for exactly 5 cycles and issues in cycle 6.
- R6: `dec_stall` is low whenever `dec_valid` is low, including during the one-slot stall and while the multiplier is busy.
- R7: While `pipe_adv` is low, the multiply's pre-access stages hold. The four-cycle tail counts down every cycle regardless of `pipe_adv`.
- R8: Synchronous active-high `rst` returns the tracker to idle, clears the tail counter and clears a pending one-slot stall.
- R9: A double-length multiply placed right behind another is stalled 5 cycles. `mul_busy` is then high in cycles 4 to 7 and again in cycles 10 to 13 after the first issue.
- R10: A multiplier-using instruction that first reaches decode in cycle 3 after a double-length multiply is stalled only until cycle 6, which is 3 stall cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds a real instruction |
| dec_class | input | 4 | Multiplier usage class of the decode instruction |
| pipe_adv | input | 1 | Global pipeline advance for this cycle |
| dec_stall | output | 1 | Hold the decode instruction this cycle |
| mul_busy | output | 1 | Multiplier tail still running |

## Verification
The bench places every class code right behind a double-length multiply. It measures the stall length for each one, so a design that stalls non-users past the single slot, or releases users one cycle early or late, shows a wrong count. Busy windows are recorded cycle by cycle under held advance. A design that froze the tail with the pipeline, or let the pre-access stages run while advance is low, would shift or stretch the window. Further cases cover a late-arriving multiplier user, back-to-back double multiplies (a design that reloads the tail too early would merge the two busy windows), invalid slots that must never stall, and a reset taken right after an issue that must also drop the pending slot stall.

// File: rtl/mbi_pkg.sv
package mbi_pkg;

    localparam int CLS_W = 4;

    localparam logic [CLS_W-1:0] CLS_NONE       = 4'd0;
    localparam logic [CLS_W-1:0] CLS_DMUL_S     = 4'd1;
    localparam logic [CLS_W-1:0] CLS_DMUL_U     = 4'd2;
    localparam logic [CLS_W-1:0] CLS_MAC_LONG   = 4'd3;
    localparam logic [CLS_W-1:0] CLS_MAC_WORD   = 4'd4;
    localparam logic [CLS_W-1:0] CLS_MUL_WORD   = 4'd5;
    localparam logic [CLS_W-1:0] CLS_RES_TO_REG = 4'd6;
    localparam logic [CLS_W-1:0] CLS_RES_TO_MEM = 4'd7;
    localparam logic [CLS_W-1:0] CLS_REG_TO_RES = 4'd8;
    localparam logic [CLS_W-1:0] CLS_MEM_TO_RES = 4'd9;

    // position of an issued double-length multiply before its multiplier access
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EX   = 2'd1,
        PH_MA1  = 2'd2,
        PH_MA2  = 2'd3
    } mul_phase_e;

endpackage

// File: rtl/mbi_class_decode.sv
module mbi_class_decode
    import mbi_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output logic             uses_mul,
    output logic             is_dlong
);

    always_comb begin
        uses_mul = 1'b0;
        is_dlong = 1'b0;
        case (cls)
            CLS_DMUL_S, CLS_DMUL_U: begin
                uses_mul = 1'b1;
                is_dlong = 1'b1;
            end
            CLS_MAC_LONG, CLS_MAC_WORD, CLS_MUL_WORD,
            CLS_RES_TO_REG, CLS_RES_TO_MEM,
            CLS_REG_TO_RES, CLS_MEM_TO_RES: begin
                uses_mul = 1'b1;
            end
            default: begin
                uses_mul = 1'b0;
                is_dlong = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mbi_issue_fsm.sv
module mbi_issue_fsm
    import mbi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  logic adv,
    output logic access_done,
    output logic pre_access,
    output logic slot_pend
);

    mul_phase_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (issue) state_d = PH_EX;
            PH_EX:   if (adv)   state_d = PH_MA1;
            PH_MA1:  if (adv)   state_d = PH_MA2;
            PH_MA2:  if (adv)   state_d = PH_IDLE;
        endcase
    end

    // one-slot decode hold after an issue
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_pend <= 1'b0;
        end else if (issue) begin
            slot_pend <= 1'b1;
        end else if (adv) begin
            slot_pend <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        access_done = 1'b0;
        pre_access  = 1'b1;
        unique case (state_q)
            PH_IDLE: pre_access  = 1'b0;
            PH_EX:   pre_access  = 1'b1;
            PH_MA1:  pre_access  = 1'b1;
            PH_MA2:  access_done = adv;
        endcase
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != PH_IDLE && !adv) |=> (state_q == $past(state_q))); // R7
    AST_SLOT_ONE: assert property (@(posedge clk) disable iff (rst)
        (slot_pend && adv) |=> !slot_pend); // R3
    AST_ISSUE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        issue |-> (state_q == PH_IDLE)); // R9

endmodule

// File: rtl/mbi_tail_counter.sv
module mbi_tail_counter #(
    parameter int TAIL_CYCLES = 4,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    output logic [CNT_W-1:0] cnt,
    output logic             busy
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TAIL_CYCLES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign busy = (cnt != '0);

    AST_TAIL_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == LOAD_VAL)); // R4
    AST_TAIL_DECR: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - ONE)); // R7

endmodule

// File: rtl/mbi_interlock.sv
module mbi_interlock
    import mbi_pkg::*;
#(
    parameter int TAIL_CYCLES = 4,
    parameter int USER_LEAD   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [CLS_W-1:0] dec_class,
    input  logic             pipe_adv,
    output logic             dec_stall,
    output logic             mul_busy
);

    localparam int CNT_W = $clog2(TAIL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LEAD_VAL = CNT_W'(USER_LEAD);

    logic             uses_mul;
    logic             is_dlong;
    logic             issue;
    logic             access_done;
    logic             pre_access;
    logic             slot_pend;
    logic [CNT_W-1:0] tail_cnt;
    logic             tail_wait;

    mbi_class_decode u_dec (
        .cls      (dec_class),
        .uses_mul (uses_mul),
        .is_dlong (is_dlong)
    );

    mbi_issue_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .issue       (issue),
        .adv         (pipe_adv),
        .access_done (access_done),
        .pre_access  (pre_access),
        .slot_pend   (slot_pend)
    );

    mbi_tail_counter #(
        .TAIL_CYCLES (TAIL_CYCLES),
        .CNT_W       (CNT_W)
    ) u_tail (
        .clk  (clk),
        .rst  (rst),
        .load (access_done),
        .cnt  (tail_cnt),
        .busy (mul_busy)
    );

    // a user leaving decode now reaches its access USER_LEAD cycles later
    assign tail_wait = (tail_cnt > LEAD_VAL);

    always_comb begin
        dec_stall = 1'b0;
        if (dec_valid) begin
            dec_stall = slot_pend | (uses_mul & (pre_access | tail_wait));
        end
    end

    assign issue = dec_valid & is_dlong & pipe_adv & ~dec_stall;

    AST_INVALID_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !dec_stall); // R6
    AST_USER_WAITS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && uses_mul && pre_access) |-> dec_stall); // R5
    AST_SLOT_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        issue |=> (!dec_valid || dec_stall)); // R3
    AST_NONUSER_FREE: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !uses_mul && !slot_pend) |-> !dec_stall); // R1

endmodule

// File: tb/test_mbi_interlock.sv
module test_mbi_interlock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_valid = 1'b0;
    logic [3:0] dec_class = 4'd0;
    logic       pipe_adv = 1'b1;
    logic       dec_stall;
    logic       mul_busy;

    always #2 clk = ~clk;

    mbi_interlock i_mbi_interlock (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (dec_valid),
        .dec_class (dec_class),
        .pipe_adv  (pipe_adv),
        .dec_stall (dec_stall),
        .mul_busy  (mul_busy)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // class code in the high nibble, expected stall cycles in the low nibble
    localparam logic [7:0] VEC [0:15] = '{
        8'h01, 8'h15, 8'h25, 8'h35, 8'h45, 8'h55, 8'h65, 8'h75,
        8'h85, 8'h95, 8'hA1, 8'hB1, 8'hC1, 8'hD1, 8'hE1, 8'hF1
    };

    // busy window monitor: bit k = busy seen in cycle k after the base cycle
    int          cyc = 0;
    int          base = 0;
    logic [31:0] busy_mask = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mul_busy && cyc >= base && cyc - base < 32) busy_mask[cyc - base] <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dec_valid = 1'b0;
            dec_class = 4'd0;
            pipe_adv  = 1'b1;
        end
    endtask

    // drive a signed double multiply into decode for cycle 0; returns after its issue edge
    task automatic issue_dmul(input bit chk);
        @(negedge clk);
        dec_valid = 1'b1;
        dec_class = 4'd1;
        pipe_adv  = 1'b1;
        base      = cyc;
        busy_mask = '0;
        #1;
        if (chk) check(dec_stall == 1'b0, "R2 idle dmul issues", int'(dec_stall), 0);
        @(posedge clk);
    endtask

    // hold class cls valid in decode until it issues; count stalled cycles
    task automatic follow(input logic [3:0] cls, output int stalls);
        stalls = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            dec_valid = 1'b1;
            dec_class = cls;
            pipe_adv  = 1'b1;
            #1;
            if (dec_stall) stalls++;
            else break;
        end
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        int s;
        // R8: reset state
        @(negedge clk);
        dec_valid = 1'b1;
        dec_class = 4'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(dec_stall == 1'b0, "R8 reset no stall", int'(dec_stall), 0);
        check(mul_busy == 1'b0, "R8 reset not busy", int'(mul_busy), 0);
        rst = 1'b0;
        idle(4);

        // table: every class right behind a double multiply
        for (int v = 0; v < 16; v++) begin
            logic [3:0] c;
            int         e;
            c = VEC[v][7:4];
            e = int'(VEC[v][3:0]);
            idle(12);
            issue_dmul(v == 0);
            follow(c, s);
            if (c == 4'd1 || c == 4'd2)
                check(s == e, $sformatf("R9 class %0d stall", c), s, e);
            else if (c >= 4'd3 && c <= 4'd9)
                check(s == e, $sformatf("R5 class %0d stall", c), s, e);
            else
                check(s == e, $sformatf("R1 R3 class %0d stall", c), s, e);
        end

        // R4: busy window with advance held high
        idle(12);
        issue_dmul(0);
        idle(14);
        check(busy_mask == 32'h0000_00F0, "R4 busy window", int'(busy_mask), 32'hF0);

        // R7: advance low in cycles 1..3 delays the access stage
        idle(4);
        issue_dmul(0);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            dec_valid = 1'b0;
            pipe_adv  = 1'b0;
        end
        idle(14);
        check(busy_mask == 32'h0000_0780, "R7 pre-access held", int'(busy_mask), 32'h780);

        // R7: advance low in cycles 5,6 does not stretch the tail
        idle(4);
        issue_dmul(0);
        idle(4);
        for (int i = 5; i <= 6; i++) begin
            @(negedge clk);
            dec_valid = 1'b0;
            pipe_adv  = 1'b0;
        end
        idle(10);
        check(busy_mask == 32'h0000_00F0, "R7 tail free-running", int'(busy_mask), 32'hF0);

        // R9: back-to-back double multiplies
        idle(4);
        issue_dmul(0);
        follow(4'd2, s);
        check(s == 5, "R9 second dmul stall", s, 5);
        idle(12);
        check(busy_mask == 32'h0000_3CF0, "R9 two busy windows", int'(busy_mask), 32'h3CF0);

        // R6 and R10: invalid slots never stall, late user waits to cycle 6
        idle(4);
        issue_dmul(0);
        @(negedge clk);
        dec_valid = 1'b0;
        dec_class = 4'd3;
        #1;
        check(dec_stall == 1'b0, "R6 invalid in slot", int'(dec_stall), 0);
        @(negedge clk);
        #1;
        check(dec_stall == 1'b0, "R6 invalid while pending", int'(dec_stall), 0);
        follow(4'd3, s);
        check(s == 3, "R10 late user stall", s, 3);

        // R10: non-user then user behind a double multiply
        idle(12);
        issue_dmul(0);
        follow(4'd0, s);
        check(s == 1, "R3 non-user one slot", s, 1);
        follow(4'd7, s);
        check(s == 3, "R10 user after non-user", s, 3);

        // R8: reset right after an issue drops slot stall and tracking
        idle(12);
        issue_dmul(0);
        @(negedge clk);
        rst       = 1'b1;
        dec_valid = 1'b0;
        @(negedge clk);
        rst       = 1'b0;
        dec_valid = 1'b1;
        dec_class = 4'd5;
        #1;
        check(dec_stall == 1'b0, "R8 reset clears pending", int'(dec_stall), 0);
        idle(10);
        check(busy_mask == 32'h0, "R8 reset clears tail", int'(busy_mask), 0);

        report();
        $finish;
    end

endmodule